// File: doc/BRIEF.md
# Performance Counter Bank with Overflow Tracking

This block holds six event counters for performance monitoring. Each counter is 48 bits wide and has a small control register. Each control register enables the counter, picks counting up or down, and allows an overflow interrupt. The counter takes an increment strobe and a decrement strobe. Its control register decides which strobe it listens to.

A counter moves only when three enables are all on at once: an upstream enable input, the counter's bit in a shared global-enable register, and its own local enable. When a counter wraps past its end, a sticky bit is set in a shared overflow status register. Writing ones to a separate clear register resets those bits. An interrupt request stays high while any counter that has its interrupt enable set also has its overflow bit set.

Software reaches every register through a flat register interface. The interface has a one-cycle write strobe, an address and 64-bit write data. Reads are combinational from the same address.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every address reads 0 and `irq` is low.
- R2: Counter n (address 0x10+n) changes by one on the clock edge after a selected event strobe, but only when three things are true: `top_en` is high, bit n of the global-enable register (address 0x00, bits 5:0) is 1, and bit 0 (enable) of control register n (address 0x08+n) is 1. Otherwise it holds its value.
- R3: When control bit 1 (direction) is 0, the counter adds one for each `inc_evt[n]` and ignores `dec_evt[n]`. When it is 1, the counter subtracts one for each `dec_evt[n]` and ignores `inc_evt[n]`.
- R4: A counting step that wraps the counter sets bit n of the overflow status register (address 0x01, bits 5:0). Upward, the wrap is from all-ones to zero. Downward, it is from zero to all-ones. The status bit changes on the same edge as the counter.
- R5: A status bit stays set until a write to the clear register (address 0x02) has a 1 at that bit position. Zero bits in the written value leave their status bits unchanged. If an overflow happens on the same edge as the clear, the bit stays set.
- R6: `irq` is high exactly while some status bit n is set and control bit 2 (interrupt enable) of counter n is 1.
- R7: A software write to counter n loads the low 48 bits on the next edge. The write wins over an event in the same cycle, and a write never sets an overflow bit.
- R8: Unused register bits read as 0. Writes to the status address have no effect. The clear register and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| top_en | input | 1 | Upstream enable, needed for any counting |
| inc_evt | input | 6 | Increment event strobes, bit n for counter n |
| dec_evt | input | 6 | Decrement event strobes, bit n for counter n |
| wr_en | input | 1 | One-cycle register write strobe |
| reg_addr | input | 5 | Register address for writes and reads |
| wr_data | input | 64 | Register write data |
| rd_data | output | 64 | Combinational read data for `reg_addr` |
| irq | output | 1 | Overflow interrupt request |

## Verification
A bad enable or direction state shows up in the counter readback one cycle after the strobe that should have moved it, or should not have. A lost or spurious status bit appears in the status read on the same edge as the wrap, and in `irq` right after. That edge also reveals a clear that drops a same-edge overflow. A status bit that decays while the counter keeps running only shows at the next status read, so the bench reads status again after further counting.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    // Register address offsets (5-bit space)
    localparam int ADDR_GLB       = 0;   // global enable vector
    localparam int ADDR_STAT      = 1;   // sticky overflow status (read only)
    localparam int ADDR_CLR       = 2;   // write-one-to-clear for status
    localparam int ADDR_CTRL_BASE = 8;   // per-counter control, +n
    localparam int ADDR_CNT_BASE  = 16;  // per-counter value, +n

    localparam int CTRL_W = 3;

    // Per-counter control fields, bit 0 upward
    typedef struct packed {
        logic irq_en;  // bit 2
        logic down;    // bit 1
        logic en;      // bit 0
    } ctr_ctrl_t;

endpackage

// File: rtl/pcb_counter.sv
module pcb_counter
    import pcb_pkg::*;
#(
    parameter int CTR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              top_en,
    input  logic              glb_en,
    input  logic              inc_evt,
    input  logic              dec_evt,
    input  logic              ctrl_wr,
    input  logic              cnt_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [CTR_W-1:0]  cnt_wdata,
    output ctr_ctrl_t         ctrl_o,
    output logic [CTR_W-1:0]  cnt_o,
    output logic              ovf_o
);

    localparam logic [CTR_W-1:0] STEP = CTR_W'(1);

    typedef struct packed {
        ctr_ctrl_t        ctrl;
        logic [CTR_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;
    logic   advance_d;
    logic   at_edge_d;

    always_comb begin
        s_d       = s_q;
        ovf_o     = 1'b0;
        advance_d = s_q.ctrl.en & glb_en & top_en &
                    (s_q.ctrl.down ? dec_evt : inc_evt);
        at_edge_d = s_q.ctrl.down ? (s_q.cnt == '0) : (&s_q.cnt);

        if (ctrl_wr) begin
            s_d.ctrl = ctr_ctrl_t'(ctrl_wdata);
        end

        if (cnt_wr) begin
            s_d.cnt = cnt_wdata;
        end else if (advance_d) begin
            s_d.cnt = s_q.ctrl.down ? (s_q.cnt - STEP) : (s_q.cnt + STEP);
            ovf_o   = at_edge_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o = s_q.ctrl;
    assign cnt_o  = s_q.cnt;

endmodule

// File: rtl/pcb_global.sv
module pcb_global #(
    parameter int NUM_CTR = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_wr,
    input  logic               clr_wr,
    input  logic [NUM_CTR-1:0] wdata,
    input  logic [NUM_CTR-1:0] ovf_in,
    input  logic [NUM_CTR-1:0] irq_en,
    output logic [NUM_CTR-1:0] glb_en_o,
    output logic [NUM_CTR-1:0] status_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [NUM_CTR-1:0] glb_en;
        logic [NUM_CTR-1:0] status;
    } state_t;

    state_t             s_d, s_q;
    logic [NUM_CTR-1:0] clr_mask_d;

    always_comb begin
        s_d        = s_q;
        clr_mask_d = clr_wr ? wdata : '0;
        if (glb_wr) begin
            s_d.glb_en = wdata;
        end
        // new overflow wins over a same-cycle clear
        s_d.status = (s_q.status & ~clr_mask_d) | ovf_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign glb_en_o = s_q.glb_en;
    assign status_o = s_q.status;
    assign irq_o    = |(s_q.status & irq_en);

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
    import pcb_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int CTR_W   = 48,
    parameter int DATA_W  = 64,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               top_en,
    input  logic [NUM_CTR-1:0] inc_evt,
    input  logic [NUM_CTR-1:0] dec_evt,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq
);

    ctr_ctrl_t                ctrl_arr [NUM_CTR];
    logic [CTR_W-1:0]         cnt_arr  [NUM_CTR];
    logic [NUM_CTR*CTR_W-1:0] cnt_flat;
    logic [NUM_CTR-1:0]       ovf_pulse;
    logic [NUM_CTR-1:0]       ovf_status;
    logic [NUM_CTR-1:0]       glb_en_vec;
    logic [NUM_CTR-1:0]       irq_en_vec;
    logic                     glb_wr;
    logic                     clr_wr;
    logic                     unused_hi;

    assign glb_wr    = wr_en && (reg_addr == ADDR_W'(ADDR_GLB));
    assign clr_wr    = wr_en && (reg_addr == ADDR_W'(ADDR_CLR));
    assign unused_hi = ^wr_data[DATA_W-1:CTR_W];

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
        logic ctrl_wr_n;
        logic cnt_wr_n;

        assign ctrl_wr_n = wr_en && (reg_addr == ADDR_W'(ADDR_CTRL_BASE + n));
        assign cnt_wr_n  = wr_en && (reg_addr == ADDR_W'(ADDR_CNT_BASE + n));

        pcb_counter #(
            .CTR_W(CTR_W)
        ) i_counter (
            .clk       (clk),
            .rst_n     (rst_n),
            .top_en    (top_en),
            .glb_en    (glb_en_vec[n]),
            .inc_evt   (inc_evt[n]),
            .dec_evt   (dec_evt[n]),
            .ctrl_wr   (ctrl_wr_n),
            .cnt_wr    (cnt_wr_n),
            .ctrl_wdata(wr_data[CTRL_W-1:0]),
            .cnt_wdata (wr_data[CTR_W-1:0]),
            .ctrl_o    (ctrl_arr[n]),
            .cnt_o     (cnt_arr[n]),
            .ovf_o     (ovf_pulse[n])
        );

        assign irq_en_vec[n]                = ctrl_arr[n].irq_en;
        assign cnt_flat[n*CTR_W +: CTR_W]   = cnt_arr[n];
    end

    pcb_global #(
        .NUM_CTR(NUM_CTR)
    ) i_global (
        .clk     (clk),
        .rst_n   (rst_n),
        .glb_wr  (glb_wr),
        .clr_wr  (clr_wr),
        .wdata   (wr_data[NUM_CTR-1:0]),
        .ovf_in  (ovf_pulse),
        .irq_en  (irq_en_vec),
        .glb_en_o(glb_en_vec),
        .status_o(ovf_status),
        .irq_o   (irq)
    );

    always_comb begin
        rd_data = '0;
        if (reg_addr == ADDR_W'(ADDR_GLB)) begin
            rd_data = DATA_W'(glb_en_vec);
        end
        if (reg_addr == ADDR_W'(ADDR_STAT)) begin
            rd_data = DATA_W'(ovf_status);
        end
        for (int i = 0; i < NUM_CTR; i++) begin
            if (reg_addr == ADDR_W'(ADDR_CTRL_BASE + i)) begin
                rd_data = DATA_W'(ctrl_arr[i]);
            end
            if (reg_addr == ADDR_W'(ADDR_CNT_BASE + i)) begin
                rd_data = DATA_W'(cnt_arr[i]);
            end
        end
    end

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
    import pcb_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int CTR_W   = 48,
    parameter int ADDR_W  = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     top_en,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [NUM_CTR-1:0]       clr_data,
    input logic                     irq,
    input logic [NUM_CTR-1:0]       ovf_pulse,
    input logic [NUM_CTR-1:0]       ovf_status,
    input logic [NUM_CTR-1:0]       glb_en_vec,
    input logic [NUM_CTR*CTR_W-1:0] cnt_flat
);

    logic [NUM_CTR-1:0] clr_mask;
    logic [NUM_CTR-1:0] keep_mask;
    logic [NUM_CTR-1:0] drop_mask;
    logic               cnt_wr_any;

    assign clr_mask   = (wr_en && reg_addr == ADDR_W'(ADDR_CLR)) ? clr_data : '0;
    assign keep_mask  = ovf_status & ~clr_mask;
    assign drop_mask  = clr_mask & ~ovf_pulse;
    assign cnt_wr_any = wr_en && (reg_addr >= ADDR_W'(ADDR_CNT_BASE)) &&
                        (reg_addr < ADDR_W'(ADDR_CNT_BASE + NUM_CTR));

    // R2: no upstream enable and no software write -> counters frozen
    p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!top_en && !cnt_wr_any) |=> $stable(cnt_flat));

    // R2: a wrap can only come from a counter that is enabled
    p_ovf_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pulse != '0) |-> (top_en && ((ovf_pulse & ~glb_en_vec) == '0)));

    // R4: a wrap sets its status bit on the next edge
    p_ovf_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pulse != '0) |=> ((ovf_status & $past(ovf_pulse)) == $past(ovf_pulse)));

    // R5: set bits not being cleared stay set
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_mask != '0) |=> ((ovf_status & $past(keep_mask)) == $past(keep_mask)));

    // R5: a clear without a same-edge wrap empties those bits
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_mask != '0) |=> ((ovf_status & $past(drop_mask)) == '0));

    // R6: request only while some status bit is set
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_status != '0));

endmodule

bind perf_ctr_bank pcb_checker #(
    .NUM_CTR(NUM_CTR),
    .CTR_W  (CTR_W),
    .ADDR_W (ADDR_W)
) i_pcb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .top_en    (top_en),
    .wr_en     (wr_en),
    .reg_addr  (reg_addr),
    .clr_data  (wr_data[NUM_CTR-1:0]),
    .irq       (irq),
    .ovf_pulse (ovf_pulse),
    .ovf_status(ovf_status),
    .glb_en_vec(glb_en_vec),
    .cnt_flat  (cnt_flat)
);

// File: tb/test_perf_ctr_bank.sv
`timescale 1ns/1ps
module test_perf_ctr_bank;

    localparam logic [47:0] MAX48 = {48{1'b1}};
    localparam logic [4:0]  A_GLB = 5'd0, A_STAT = 5'd1, A_CLR = 5'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        top_en = 1'b0;
    logic [5:0]  inc_evt = '0;
    logic [5:0]  dec_evt = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    perf_ctr_bank i_perf_ctr_bank (
        .clk(clk), .rst_n(rst_n), .top_en(top_en), .inc_evt(inc_evt),
        .dec_evt(dec_evt), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [4:0] a_ctrl(input int n); return 5'(8 + n);  endfunction
    function automatic logic [4:0] a_cnt (input int n); return 5'(16 + n); endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [63:0] exp);
        reg_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic pulse(input logic [5:0] inc, input logic [5:0] dec, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            inc_evt = inc; dec_evt = dec;
        end
        @(negedge clk);
        inc_evt = '0; dec_evt = '0;
    endtask

    // write and event in the same cycle
    task automatic wr_with_evt(input logic [4:0] a, input logic [63:0] d,
                               input logic [5:0] inc, input logic [5:0] dec);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d; inc_evt = inc; dec_evt = dec;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; inc_evt = '0; dec_evt = '0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 32; a++) rd_chk("R1 reset read", 5'(a), 64'h0);
        check("R1 irq low", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_enables;
        top_en = 1'b1;
        wr(a_ctrl(0), 64'h1);
        pulse(6'h01, 6'h00, 3);
        rd_chk("R2 global bit off", a_cnt(0), 64'd0);
        wr(A_GLB, 64'h01);
        top_en = 1'b0;
        pulse(6'h01, 6'h00, 3);
        rd_chk("R2 upstream off", a_cnt(0), 64'd0);
        top_en = 1'b1;
        pulse(6'h01, 6'h00, 3);
        rd_chk("R2 all enables", a_cnt(0), 64'd3);
        wr(A_GLB, 64'h03);
        pulse(6'h02, 6'h00, 2);
        rd_chk("R2 local bit off", a_cnt(1), 64'd0);
    endtask

    task automatic t_direction;
        wr(A_GLB, 64'h3F);
        wr(a_ctrl(2), 64'h3);
        wr(a_cnt(2), 64'd10);
        pulse(6'h04, 6'h00, 2);
        rd_chk("R3 down ignores inc", a_cnt(2), 64'd10);
        pulse(6'h00, 6'h04, 3);
        rd_chk("R3 down counts dec", a_cnt(2), 64'd7);
        pulse(6'h00, 6'h01, 2);
        rd_chk("R3 up ignores dec", a_cnt(0), 64'd3);
    endtask

    task automatic t_overflow;
        wr(a_ctrl(3), 64'h5);
        wr(a_cnt(3), {16'h0, MAX48 - 48'd1});
        pulse(6'h08, 6'h00, 1);
        rd_chk("R4 at max no flag", A_STAT, 64'h0);
        pulse(6'h08, 6'h00, 1);
        rd_chk("R4 up wrap value", a_cnt(3), 64'd0);
        rd_chk("R4 up wrap flag", A_STAT, 64'h08);
        check("R6 irq raised", {63'h0, irq}, 64'h1);
        pulse(6'h08, 6'h00, 2);
        rd_chk("R5 sticky while running", A_STAT, 64'h08);
        wr(a_ctrl(4), 64'h3);
        pulse(6'h00, 6'h10, 1);
        rd_chk("R4 down wrap value", a_cnt(4), {16'h0, MAX48});
        rd_chk("R4 down wrap flag", A_STAT, 64'h18);
    endtask

    task automatic t_clear;
        wr(A_CLR, 64'h0);
        rd_chk("R5 zero clear no effect", A_STAT, 64'h18);
        wr(A_CLR, 64'h08);
        rd_chk("R5 clear one bit", A_STAT, 64'h10);
        check("R6 masked bit no irq", {63'h0, irq}, 64'h0);
        wr(A_CLR, 64'h10);
        rd_chk("R5 clear last bit", A_STAT, 64'h0);
    endtask

    task automatic t_simultaneous;
        wr(a_ctrl(5), 64'h5);
        wr(a_cnt(5), {16'h0, MAX48});
        wr_with_evt(A_CLR, 64'h20, 6'h20, 6'h00);
        rd_chk("R5 wrap beats clear", A_STAT, 64'h20);
        check("R6 irq held", {63'h0, irq}, 64'h1);
        wr(A_CLR, 64'h20);
        check("R6 irq dropped", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_priority;
        wr_with_evt(a_cnt(0), 64'd100, 6'h01, 6'h00);
        rd_chk("R7 write beats event", a_cnt(0), 64'd100);
        wr(a_cnt(0), {16'h0, MAX48});
        wr_with_evt(a_cnt(2), 64'd0, 6'h00, 6'h04);
        rd_chk("R7 down write beats event", a_cnt(2), 64'd0);
        rd_chk("R7 writes no flag", A_STAT, 64'h0);
        pulse(6'h01, 6'h00, 1);
        rd_chk("R7 written max then wraps", A_STAT, 64'h01);
        wr(A_CLR, 64'h01);
    endtask

    task automatic t_read_map;
        wr(a_ctrl(1), {64{1'b1}});
        rd_chk("R8 ctrl unused bits", a_ctrl(1), 64'h7);
        wr(A_GLB, {64{1'b1}});
        rd_chk("R8 global unused bits", A_GLB, 64'h3F);
        wr(A_STAT, {64{1'b1}});
        rd_chk("R8 status not writable", A_STAT, 64'h0);
        wr(A_CLR, 64'h0);
        rd_chk("R8 clear reads zero", A_CLR, 64'h0);
        wr(a_cnt(1), 64'hABCD_0000_0000_1234);
        rd_chk("R8 counter upper bits", a_cnt(1), 64'h1234);
        rd_chk("R8 unmapped reads zero", 5'd3, 64'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enables();
        t_direction();
        t_overflow();
        t_clear();
        t_simultaneous();
        t_priority();
        t_read_map();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule